// File: doc/BRIEF.md
# Non-Posted Completion Tag Tracker

This block keeps a table of requests that are still waiting for a response. When the request side issues a transaction, the block decodes its kind. Kinds that need no response pass through and leave the table untouched. Kinds that need a completion take the lowest free tag. The entry holds the requester identity and the number of bytes still expected back.

Each completion that arrives is looked up by its tag and then compared on requester identity. One clock later the block reports the outcome on a response interface: the completion status, the completer identity, how many bytes are still outstanding, and whether the entry was retired. A completion that matches no live entry is flagged as unexpected and otherwise dropped. Every entry also ages against a programmable limit. When an entry waits too long it is retired and a one-cycle timeout pulse names its tag and requester.

Top module: `cpl_tag_tracker`

## Requirements
- R1: The request kind code on `req_kind` decides tracking. Codes 2 (memory read), 3 (I/O read), 4 (I/O write), 5 (configuration read) and 6 (configuration write) need a completion: `req_tracked` is high and, once accepted, an entry is taken. Codes 0 (memory write), 1 (message) and 7 take no entry, `req_tracked` is low, and `req_ready` is always high for them.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. A tracked request takes the lowest-numbered free tag, and `req_tag` shows that tag in the same cycle.
- R3: When all NUM_TAGS entries are in use, `req_ready` is low for tracked kinds and no entry changes.
- R4: Read kinds (2, 3, 5) store `req_bytes` as the outstanding byte count. Write kinds (4, 6) store zero, whatever `req_bytes` holds.
- R5: A completion matches when the entry at `cpl_tag` is in use and its stored requester ID equals `cpl_rid`. Without a match, the next cycle shows `rsp_valid`=1, `rsp_unexp`=1, `rsp_err`=0, `rsp_done`=0 and `rsp_remain`=0, and the table is unchanged.
- R6: A matching completion with status 0 (success) lowers the outstanding count by `cpl_bytes`. `rsp_remain` shows the new count. The entry is retired, with `rsp_done`=1 and `rsp_remain`=0, once the count reaches zero or `cpl_bytes` is at least the count.
- R7: A matching completion with any nonzero status retires its entry at once. Examples are 1 (unsupported request), 2 (retry) and 4 (abort). The response shows `rsp_err`=1, `rsp_done`=1 and `rsp_remain`=0.
- R8: Every response echoes `cpl_tag`, `cpl_cid` and `cpl_status` of its completion on `rsp_tag`, `rsp_cid` and `rsp_status`, one cycle after `cpl_valid`.
- R9: Take an entry accepted at rising edge E and not completed since. At edge E+`to_limit`+1 it is retired, and `to_valid` is high for one cycle with its tag on `to_tag` and its requester on `to_rid`.
- R10: After reset all entries are free, `req_ready`=1, `req_tag`=0, `rsp_valid`=0 and `to_valid`=0.
- R11: A retired tag can be taken again. Until it is re-issued, a completion carrying it is unexpected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| to_limit | input | AGE_W | Timeout limit in cycles |
| req_valid | input | 1 | Request offered |
| req_kind | input | 3 | Request kind code |
| req_rid | input | RID_W | Requester ID (bus/device/function) |
| req_bytes | input | BC_W | Bytes requested (reads) |
| req_ready | output | 1 | Request can be accepted |
| req_tag | output | TAG_W | Tag given to a tracked request |
| req_tracked | output | 1 | Offered kind needs a completion |
| cpl_valid | input | 1 | Completion arrives |
| cpl_rid | input | RID_W | Requester ID carried by the completion |
| cpl_cid | input | RID_W | Completer ID |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cpl_status | input | 3 | Completion status code |
| cpl_bytes | input | BC_W | Payload bytes in this completion |
| rsp_valid | output | 1 | Completion outcome valid |
| rsp_tag | output | TAG_W | Tag of the completion |
| rsp_cid | output | RID_W | Completer ID echoed |
| rsp_status | output | 3 | Status echoed |
| rsp_unexp | output | 1 | Completion matched no entry |
| rsp_err | output | 1 | Matched with error status |
| rsp_remain | output | BC_W | Bytes still outstanding |
| rsp_done | output | 1 | Entry retired |
| to_valid | output | 1 | Timeout pulse |
| to_tag | output | TAG_W | Tag that timed out |
| to_rid | output | RID_W | Requester of the timed-out entry |

## Verification
Each kind code is issued with non-posted requests placed around posted ones, so that a wrongly tracked posted request shows up as a skipped tag. Completions are driven in several forms: split reads, an exact final chunk, an overrunning chunk, zero-byte write completions, an error status, a stale tag and a correct tag with the wrong requester. Together these separate the decrement path, the retire path and the identity comparison. A fill to all tags shows refusal when the table is full and reuse of a freed tag. A short limit shows the exact cycle of the timeout pulse.

// File: rtl/cpl_trk_pkg.sv
// Shared encodings for the completion tag tracker.
// Assumes 3-bit kind and status codes as listed in the brief.
package cpl_trk_pkg;

    typedef enum logic [2:0] {
        K_MEM_WR = 3'd0,
        K_MSG    = 3'd1,
        K_MEM_RD = 3'd2,
        K_IO_RD  = 3'd3,
        K_IO_WR  = 3'd4,
        K_CFG_RD = 3'd5,
        K_CFG_WR = 3'd6,
        K_RSVD   = 3'd7
    } req_kind_e;

    localparam logic [2:0] ST_OK = 3'd0;

    // True for kinds that wait for a completion.
    function automatic logic needs_cpl(input logic [2:0] k);
        return (k >= 3'd2) && (k <= 3'd6);
    endfunction

    // True for kinds whose completion returns data.
    function automatic logic returns_data(input logic [2:0] k);
        return (k == 3'd2) || (k == 3'd3) || (k == 3'd5);
    endfunction

endpackage

// File: rtl/cpl_trk_pick.sv
// Lowest-index finder: reports whether any request bit is set and the
// index of the lowest one. Assumes N >= 2.
module cpl_trk_pick #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cpl_trk_entry.sv
// One tracking entry: holds the in-use flag, requester ID, outstanding byte
// count and an age counter. The top supplies the already-computed next count
// for a completion hit, so each entry has no subtractor of its own.
// Assumes alloc, hit and expire are never set for a busy/free mismatch.
module cpl_trk_entry #(
    parameter int RID_W = 16,
    parameter int BC_W  = 13,
    parameter int AGE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [RID_W-1:0] alloc_rid,
    input  logic [BC_W-1:0]  alloc_bytes,
    input  logic             hit,
    input  logic             hit_free,
    input  logic [BC_W-1:0]  hit_remain,
    input  logic             expire,
    input  logic [AGE_W-1:0] to_limit,
    output logic             valid_o,
    output logic [RID_W-1:0] rid_o,
    output logic [BC_W-1:0]  remain_o,
    output logic             aged_o
);
    logic             valid_q;
    logic [RID_W-1:0] rid_q;
    logic [BC_W-1:0]  remain_q;
    logic [AGE_W-1:0] age_q;

    // Entry state update: allocate, then completion, then timeout, then ageing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            rid_q    <= '0;
            remain_q <= '0;
            age_q    <= '0;
        end else if (alloc) begin
            valid_q  <= 1'b1;
            rid_q    <= alloc_rid;
            remain_q <= alloc_bytes;
            age_q    <= '0;
        end else if (hit) begin
            remain_q <= hit_remain;
            if (hit_free) valid_q <= 1'b0;
        end else if (expire) begin
            valid_q <= 1'b0;
        end else if (valid_q && (age_q < to_limit)) begin
            age_q <= age_q + 1'b1;
        end
    end

    // Entry outputs toward the table logic.
    always_comb begin
        valid_o  = valid_q;
        rid_o    = rid_q;
        remain_o = remain_q;
        aged_o   = valid_q && (age_q >= to_limit);
    end

    // R9
    alloc_clears_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (valid_q && (age_q == '0)));

    // R6
    remain_never_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !alloc) |=> (remain_q <= $past(remain_q)));
endmodule

// File: rtl/cpl_tag_tracker.sv
// Non-posted request completion tracker. Tags equal table indices, so a
// completion is looked up directly by tag and confirmed by requester ID.
// One completion and one request per cycle; responses and timeouts are
// registered. Assumes NUM_TAGS is a power of two so every tag is an index.
module cpl_tag_tracker
    import cpl_trk_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int RID_W    = 16,
    parameter int BC_W     = 13,
    parameter int AGE_W    = 16,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AGE_W-1:0] to_limit,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [RID_W-1:0] req_rid,
    input  logic [BC_W-1:0]  req_bytes,
    output logic             req_ready,
    output logic [TAG_W-1:0] req_tag,
    output logic             req_tracked,
    input  logic             cpl_valid,
    input  logic [RID_W-1:0] cpl_rid,
    input  logic [RID_W-1:0] cpl_cid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [2:0]       cpl_status,
    input  logic [BC_W-1:0]  cpl_bytes,
    output logic             rsp_valid,
    output logic [TAG_W-1:0] rsp_tag,
    output logic [RID_W-1:0] rsp_cid,
    output logic [2:0]       rsp_status,
    output logic             rsp_unexp,
    output logic             rsp_err,
    output logic [BC_W-1:0]  rsp_remain,
    output logic             rsp_done,
    output logic             to_valid,
    output logic [TAG_W-1:0] to_tag,
    output logic [RID_W-1:0] to_rid
);
    logic [NUM_TAGS-1:0] valid_vec, aged_vec;
    logic [NUM_TAGS-1:0] alloc_vec, hit_vec, expire_vec;
    logic [RID_W-1:0]    rid_arr [NUM_TAGS];
    logic [BC_W-1:0]     rem_arr [NUM_TAGS];

    logic             free_any, age_any;
    logic [TAG_W-1:0] free_idx, age_idx;
    logic             alloc_fire;
    logic [BC_W-1:0]  alloc_bytes;
    logic             cpl_match, cpl_ok, cpl_free;
    logic [BC_W-1:0]  sel_rem, next_rem;

    // Lowest free tag for the next tracked request.
    cpl_trk_pick #(.N(NUM_TAGS)) u_free_pick (
        .req (~valid_vec),
        .any (free_any),
        .idx (free_idx)
    );

    // Lowest aged entry, skipping one that a completion retires this cycle.
    cpl_trk_pick #(.N(NUM_TAGS)) u_age_pick (
        .req (aged_vec & ~hit_vec),
        .any (age_any),
        .idx (age_idx)
    );

    // Request decode and acceptance.
    always_comb begin
        req_tracked = needs_cpl(req_kind);
        req_ready   = !req_tracked || free_any;
        req_tag     = free_idx;
        alloc_fire  = req_valid && req_tracked && free_any;
        alloc_bytes = returns_data(req_kind) ? req_bytes : '0;
    end

    // Completion lookup and shared byte-count update.
    always_comb begin
        sel_rem   = rem_arr[cpl_tag];
        cpl_match = cpl_valid && valid_vec[cpl_tag] && (rid_arr[cpl_tag] == cpl_rid);
        cpl_ok    = (cpl_status == ST_OK);
        cpl_free  = !cpl_ok || (cpl_bytes >= sel_rem);
        next_rem  = cpl_free ? '0 : (sel_rem - cpl_bytes);
    end

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_ent
        assign alloc_vec[g]  = alloc_fire && (free_idx == TAG_W'(g));
        assign hit_vec[g]    = cpl_match && (cpl_tag == TAG_W'(g));
        assign expire_vec[g] = age_any && (age_idx == TAG_W'(g));

        cpl_trk_entry #(
            .RID_W (RID_W),
            .BC_W  (BC_W),
            .AGE_W (AGE_W)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (alloc_vec[g]),
            .alloc_rid   (req_rid),
            .alloc_bytes (alloc_bytes),
            .hit         (hit_vec[g]),
            .hit_free    (cpl_free),
            .hit_remain  (next_rem),
            .expire      (expire_vec[g]),
            .to_limit    (to_limit),
            .valid_o     (valid_vec[g]),
            .rid_o       (rid_arr[g]),
            .remain_o    (rem_arr[g]),
            .aged_o      (aged_vec[g])
        );
    end

    // Registered completion outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_tag    <= '0;
            rsp_cid    <= '0;
            rsp_status <= '0;
            rsp_unexp  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_remain <= '0;
            rsp_done   <= 1'b0;
        end else begin
            rsp_valid  <= cpl_valid;
            rsp_tag    <= cpl_tag;
            rsp_cid    <= cpl_cid;
            rsp_status <= cpl_status;
            rsp_unexp  <= cpl_valid && !cpl_match;
            rsp_err    <= cpl_match && !cpl_ok;
            rsp_remain <= cpl_match ? next_rem : '0;
            rsp_done   <= cpl_match && cpl_free;
        end
    end

    // Registered timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_valid <= 1'b0;
            to_tag   <= '0;
            to_rid   <= '0;
        end else begin
            to_valid <= age_any;
            to_tag   <= age_idx;
            to_rid   <= rid_arr[age_idx];
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && needs_cpl(req_kind) && (&valid_vec)) |-> !req_ready);

    // R2
    alloc_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_tracked) |=> valid_vec[$past(req_tag)]);

    // R5
    unexp_side_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_unexp |-> (rsp_valid && !rsp_err && !rsp_done && (rsp_remain == '0)));

    // R7
    err_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && (rsp_status != ST_OK)));

    // R9
    timeout_vs_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_valid && rsp_done) |-> (to_tag != rsp_tag));

    // R9
    timeout_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age_any |=> !valid_vec[$past(age_idx)] || $past(alloc_fire));
endmodule

// File: tb/cpl_tag_tracker_test.sv
module cpl_tag_tracker_test;
    localparam int TW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] to_limit = 16'd1000;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_rid = '0;
    logic [12:0] req_bytes = '0;
    logic        req_ready, req_tracked;
    logic [TW-1:0] req_tag;
    logic        cpl_valid = 1'b0;
    logic [15:0] cpl_rid = '0, cpl_cid = '0;
    logic [TW-1:0] cpl_tag = '0;
    logic [2:0]  cpl_status = '0;
    logic [12:0] cpl_bytes = '0;
    logic        rsp_valid, rsp_unexp, rsp_err, rsp_done;
    logic [TW-1:0] rsp_tag;
    logic [15:0] rsp_cid;
    logic [2:0]  rsp_status;
    logic [12:0] rsp_remain;
    logic        to_valid;
    logic [TW-1:0] to_tag;
    logic [15:0] to_rid;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cpl_tag_tracker uut (
        .clk(clk), .rst_n(rst_n), .to_limit(to_limit),
        .req_valid(req_valid), .req_kind(req_kind), .req_rid(req_rid),
        .req_bytes(req_bytes), .req_ready(req_ready), .req_tag(req_tag),
        .req_tracked(req_tracked),
        .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_cid(cpl_cid),
        .cpl_tag(cpl_tag), .cpl_status(cpl_status), .cpl_bytes(cpl_bytes),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_cid(rsp_cid),
        .rsp_status(rsp_status), .rsp_unexp(rsp_unexp), .rsp_err(rsp_err),
        .rsp_remain(rsp_remain), .rsp_done(rsp_done),
        .to_valid(to_valid), .to_tag(to_tag), .to_rid(to_rid)
    );

    typedef struct packed {
        logic        op;      // 0 issue, 1 completion
        logic [2:0]  kind;
        logic [15:0] rid;
        logic [4:0]  tag;
        logic [2:0]  st;
        logic [12:0] nb;
        logic        e_rdy;
        logic        e_trk;
        logic [4:0]  e_tag;
        logic        e_unexp;
        logic        e_err;
        logic        e_done;
        logic [12:0] e_rem;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd2, 16'h0100, 5'd0, 3'd0, 13'd64, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 13'd0},
        '{1'b0, 3'd0, 16'h0100, 5'd0, 3'd0, 13'd8,  1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 13'd0},
        '{1'b0, 3'd6, 16'h0200, 5'd0, 3'd0, 13'd0,  1'b1, 1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 13'd0},
        '{1'b0, 3'd3, 16'h0300, 5'd0, 3'd0, 13'd4,  1'b1, 1'b1, 5'd2, 1'b0, 1'b0, 1'b0, 13'd0},
        '{1'b1, 3'd0, 16'h0100, 5'd0, 3'd0, 13'd32, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 13'd32},
        '{1'b1, 3'd0, 16'h0100, 5'd0, 3'd0, 13'd32, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 13'd0},
        '{1'b1, 3'd0, 16'h0100, 5'd0, 3'd0, 13'd4,  1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 13'd0},
        '{1'b1, 3'd0, 16'h0999, 5'd1, 3'd0, 13'd0,  1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 13'd0},
        '{1'b1, 3'd0, 16'h0200, 5'd1, 3'd0, 13'd0,  1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 13'd0},
        '{1'b1, 3'd0, 16'h0300, 5'd2, 3'd1, 13'd0,  1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 13'd0},
        '{1'b0, 3'd1, 16'h0100, 5'd0, 3'd0, 13'd0,  1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 13'd0},
        '{1'b0, 3'd2, 16'h0400, 5'd0, 3'd0, 13'd16, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 13'd0},
        '{1'b1, 3'd0, 16'h0400, 5'd0, 3'd0, 13'd24, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 13'd0},
        '{1'b0, 3'd4, 16'h0500, 5'd0, 3'd0, 13'd8,  1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 13'd0},
        '{1'b1, 3'd0, 16'h0500, 5'd0, 3'd0, 13'd0,  1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 13'd0}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_issue(input logic [2:0] k, input logic [15:0] rid, input logic [12:0] nb,
                            output logic rdy, output logic trk, output logic [TW-1:0] tg);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_rid = rid; req_bytes = nb;
        #1;
        rdy = req_ready; trk = req_tracked; tg = req_tag;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_cpl(input logic [15:0] rid, input logic [TW-1:0] tg,
                          input logic [2:0] st, input logic [12:0] nb);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_rid = rid; cpl_cid = rid + 16'h1000;
        cpl_tag = tg; cpl_status = st; cpl_bytes = nb;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic rdy, trk;
        logic [TW-1:0] tg;
        vec_t v;

        // R10: reset state
        do_reset();
        @(negedge clk);
        chk("R10 req_ready", req_ready, 1);
        chk("R10 req_tag", req_tag, 0);
        chk("R10 rsp_valid", rsp_valid, 0);
        chk("R10 to_valid", to_valid, 0);

        // Vector table: R1 kinds, R2 tags, R4 write stores zero (vectors 13-14),
        // R5 mismatch, R6 byte counting, R7 error status, R8 echo, R11 reuse.
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            if (!v.op) begin
                do_issue(v.kind, v.rid, v.nb, rdy, trk, tg);
                chk("R1 req_ready", rdy, v.e_rdy);
                chk("R1 req_tracked", trk, v.e_trk);
                if (v.e_trk) chk("R2 req_tag", tg, v.e_tag);
            end else begin
                do_cpl(v.rid, v.tag, v.st, v.nb);
                chk("R8 rsp_valid", rsp_valid, 1);
                chk("R8 rsp_tag", rsp_tag, v.tag);
                chk("R8 rsp_cid", rsp_cid, v.rid + 16'h1000);
                chk("R8 rsp_status", rsp_status, v.st);
                chk("R5 rsp_unexp", rsp_unexp, v.e_unexp);
                chk("R7 rsp_err", rsp_err, v.e_err);
                chk("R6 rsp_done", rsp_done, v.e_done);
                chk("R6 rsp_remain", rsp_remain, v.e_rem);
            end
        end
        @(negedge clk);
        chk("R8 rsp_valid drops", rsp_valid, 0);

        // R3: fill every tag, then refuse further tracked requests
        do_reset();
        for (int i = 0; i < 32; i++) begin
            do_issue(3'd2, 16'h0700, 13'd4, rdy, trk, tg);
            chk("R2 fill tag", tg, i);
            chk("R2 fill ready", rdy, 1);
        end
        do_issue(3'd5, 16'h0700, 13'd4, rdy, trk, tg);
        chk("R3 full refuses", rdy, 0);
        do_issue(3'd0, 16'h0700, 13'd4, rdy, trk, tg);
        chk("R1 posted when full", rdy, 1);
        // R3: the refused request took nothing, so tag 17 completes normally
        do_cpl(16'h0700, 5'd17, 3'd0, 13'd4);
        chk("R6 full done", rsp_done, 1);
        // R11: freed tag is handed out again
        do_issue(3'd2, 16'h0800, 13'd4, rdy, trk, tg);
        chk("R11 reuse ready", rdy, 1);
        chk("R11 reuse tag", tg, 17);
        do_cpl(16'h0700, 5'd17, 3'd0, 13'd4);
        chk("R11 old rid unexpected", rsp_unexp, 1);

        // R9: timeout after to_limit+1 edges
        to_limit = 16'd5;
        do_reset();
        do_issue(3'd2, 16'h0A00, 13'd8, rdy, trk, tg);
        chk("R9 issue tag", tg, 0);
        for (int n = 1; n <= 7; n++) begin
            @(negedge clk);
            chk("R9 to_valid timing", to_valid, (n == 6) ? 1 : 0);
            if (n == 6) begin
                chk("R9 to_tag", to_tag, 0);
                chk("R9 to_rid", to_rid, 16'h0A00);
            end
        end
        do_cpl(16'h0A00, 5'd0, 3'd0, 13'd8);
        chk("R9 timed-out entry gone", rsp_unexp, 1);

        finish_run();
    end
endmodule